// File: doc/BRIEF.md
# Time-Aware Cycle Start Generator

This block produces the repeating schedule cycle for one transmit port of a time-aware traffic shaper. It keeps a free-running 64-bit time value in nanoseconds that advances on every reference clock by a programmable step. The step is the increment input plus one. It also holds a 64-bit administrative base time. Once the block is enabled and the time value reaches the base time, it starts emitting a one-clock cycle-start pulse. It then repeats that pulse every `cycle_len` reference clocks, so the cycle lasts `cycle_len * (incr + 1)` nanoseconds.

Software loads the base time in two 32-bit halves. The low half is only staged. Both halves take effect together when the high half is written, so the comparison never sees half of an old value and half of a new one. While cycles are running, a new non-zero base time is refused. The running schedule can only be re-anchored by stopping it first. Writing zero is still accepted, because a zero base time lies in the past. When the enable is dropped, the schedule stops at the next clock.

Top module: `cycle_start_gen`

## Requirements
- R1: `time_ns` is 0 after reset. On every clock edge with reset low it grows by `incr + 1`, wrapping modulo 2^64.
- R2: While `rst` is high, `time_ns`, `running` and `cycle_start` are all 0 one edge later.
- R3: A write with `base_lo_we` only stages the low 32 bits and does not change the active base time. A write with `base_hi_we` forms the new base from `base_wdata` as bits 63:32 and the staged low word as bits 31:0.
- R4: If `en` is high, the block is not running, and `time_ns >= base` at a clock edge, then `running` and `cycle_start` are both 1 after that edge. A base time that is already past therefore starts the schedule one clock after enable.
- R5: While enabled with `time_ns < base`, no pulse is produced and `running` stays 0. The comparison is greater-or-equal, so a step that jumps over the exact base value still starts the schedule.
- R6: While running, consecutive `cycle_start` pulses are exactly `cycle_len` clocks apart. A `cycle_len` of 0 behaves like 1, giving a pulse on every clock.
- R7: With `cycle_len >= 2`, `cycle_start` is high for exactly one clock per cycle, and it is only ever high while `running` is high.
- R8: A high-word write arriving while `running` is 1 is ignored unless the assembled 64-bit base is zero, in which case it is accepted.
- R9: If `en` is low at a clock edge, `running` and `cycle_start` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Schedule enable |
| base_lo_we | input | 1 | Stage `base_wdata` as base-time bits 31:0 |
| base_hi_we | input | 1 | Commit `base_wdata` as bits 63:32 together with the staged low word |
| base_wdata | input | 32 | Base-time write data |
| cycle_len | input | 16 | Cycle length in reference clocks |
| incr | input | 8 | Time step minus one, in nanoseconds |
| time_ns | output | 64 | Current time value |
| cycle_start | output | 1 | One-clock pulse at the start of each cycle |
| running | output | 1 | Schedule is generating cycles |

## Verification
The bound checker checks these behaviours on every cycle:
- the exact time step (R1);
- the reset values (R2);
- the start pulse that coincides with `running` rising (R4);
- the silence while the base time is still ahead (R5);
- the pulse spacing, measured with a gap counter against `cycle_len` (R6);
- pulse width and containment (R7);
- the base lock while running (R8);
- the one-clock stop (R9).

Other behaviours only the bench scenarios can show: that a lone low-word write leaves the schedule anchored to the old base; that a refused base really leaves the old value in effect after a restart; and that the start lands in the right clock when the step jumps over a base value that is not a multiple of the step. The bench shows these by comparing its behavioural model with every output on every clock.

// File: rtl/cstg_pkg.sv
package cstg_pkg;

  typedef enum logic [1:0] {
    GS_OFF  = 2'd0,
    GS_WAIT = 2'd1,
    GS_RUN  = 2'd2
  } gen_state_e;

  // Effective cycle length: zero behaves like one
  function automatic logic [31:0] eff_len(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

endpackage

// File: rtl/cstg_time_counter.sv
module cstg_time_counter #(
  parameter int TIME_W = 64,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INC_W-1:0]  incr,
  output logic [TIME_W-1:0] time_q
);

  localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

  logic [TIME_W-1:0] step;
  assign step = TIME_W'(incr) + ONE;

  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= time_q + step;
  end

endmodule

// File: rtl/cstg_base_reg.sv
module cstg_base_reg #(
  parameter int TIME_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic [TIME_W/2-1:0] wdata,
  input  logic                lock,
  output logic [TIME_W-1:0]   base_q
);

  localparam int HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] lo_stage;
  logic [TIME_W-1:0] cand;
  logic              accept;

  assign cand   = {wdata, lo_stage};
  assign accept = hi_we && (!lock || (cand == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage <= '0;
      base_q   <= '0;
    end else begin
      if (lo_we)  lo_stage <= wdata;
      if (accept) base_q   <= cand;
    end
  end

endmodule

// File: rtl/cstg_cycle_ctrl.sv
module cstg_cycle_ctrl
  import cstg_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [TIME_W-1:0] time_q,
  input  logic [TIME_W-1:0] base_q,
  input  logic [LEN_W-1:0]  len,
  output logic              start_q,
  output logic              running
);

  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

  gen_state_e       st;
  logic [LEN_W-1:0] cnt;
  logic             reached;
  logic             wrap;

  assign reached = (time_q >= base_q);
  assign wrap    = (cnt >= len);
  assign running = (st == GS_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= GS_OFF;
      start_q <= 1'b0;
      cnt     <= '0;
    end else if (!en) begin
      st      <= GS_OFF;
      start_q <= 1'b0;
      cnt     <= '0;
    end else begin
      case (st)
        GS_RUN: begin
          if (wrap) begin
            start_q <= 1'b1;
            cnt     <= CNT_ONE;
          end else begin
            start_q <= 1'b0;
            cnt     <= cnt + CNT_ONE;
          end
        end
        default: begin
          if (reached) begin
            st      <= GS_RUN;
            start_q <= 1'b1;
            cnt     <= CNT_ONE;
          end else begin
            st      <= GS_WAIT;
            start_q <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cycle_start_gen.sv
module cycle_start_gen #(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8,
  localparam int HALF_W = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              base_lo_we,
  input  logic              base_hi_we,
  input  logic [HALF_W-1:0] base_wdata,
  input  logic [LEN_W-1:0]  cycle_len,
  input  logic [INC_W-1:0]  incr,
  output logic [TIME_W-1:0] time_ns,
  output logic              cycle_start,
  output logic              running
);

  logic [TIME_W-1:0] base_cur;
  logic              run_int;

  cstg_time_counter #(.TIME_W(TIME_W), .INC_W(INC_W)) u_time (
    .clk    (clk),
    .rst    (rst),
    .incr   (incr),
    .time_q (time_ns)
  );

  cstg_base_reg #(.TIME_W(TIME_W)) u_base (
    .clk    (clk),
    .rst    (rst),
    .lo_we  (base_lo_we),
    .hi_we  (base_hi_we),
    .wdata  (base_wdata),
    .lock   (run_int),
    .base_q (base_cur)
  );

  cstg_cycle_ctrl #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .time_q  (time_ns),
    .base_q  (base_cur),
    .len     (cycle_len),
    .start_q (cycle_start),
    .running (run_int)
  );

  assign running = run_int;

endmodule

// File: rtl/cstg_checker.sv
module cstg_checker #(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [TIME_W-1:0] time_ns,
  input logic [TIME_W-1:0] base_q,
  input logic [LEN_W-1:0]  cycle_len,
  input logic [INC_W-1:0]  incr,
  input logic              cycle_start,
  input logic              running
);

  localparam logic [LEN_W:0] GAP_MAX = {(LEN_W+1){1'b1}};

  // Clocks since the last visible pulse while running
  logic [LEN_W:0] gap;
  logic [LEN_W:0] len_eff;

  assign len_eff = (cycle_len == '0) ? (LEN_W+1)'(1) : {1'b0, cycle_len};

  always_ff @(posedge clk) begin
    if (rst || !running)    gap <= '0;
    else if (cycle_start)   gap <= (LEN_W+1)'(1);
    else if (gap != GAP_MAX) gap <= gap + (LEN_W+1)'(1);
  end

  p_time_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> time_ns == $past(time_ns) + TIME_W'($past(incr)) + TIME_W'(1));

  p_reset_r2: assert property (@(posedge clk)
    rst |=> (time_ns == '0) && !running && !cycle_start);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> cycle_start);

  p_wait_early_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !running && (time_ns < base_q)) |=> (!running && !cycle_start));

  p_period_r6: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && (gap != '0) && $stable(cycle_len)) |-> (gap == len_eff));

  p_in_run_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> running);

  p_one_wide_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cycle_start && $past(cycle_start)) |-> ($past(cycle_len) <= LEN_W'(1)));

  p_base_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(running) && !$stable(base_q)) |-> (base_q == '0));

  p_stop_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!running && !cycle_start));

endmodule

bind cycle_start_gen cstg_checker #(
  .TIME_W(TIME_W), .LEN_W(LEN_W), .INC_W(INC_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .time_ns     (time_ns),
  .base_q      (base_cur),
  .cycle_len   (cycle_len),
  .incr        (incr),
  .cycle_start (cycle_start),
  .running     (running)
);

// File: tb/cycle_start_gen_tb.sv
`timescale 1ns/1ps
module cycle_start_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        base_lo_we = 1'b0;
  logic        base_hi_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [15:0] cycle_len = 16'd4;
  logic [7:0]  incr = 8'd9;
  logic [63:0] time_ns;
  logic        cycle_start;
  logic        running;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cycle_start_gen u_dut (
    .clk, .rst, .en, .base_lo_we, .base_hi_we, .base_wdata,
    .cycle_len, .incr, .time_ns, .cycle_start, .running
  );

  // Behavioural reference model
  longint unsigned m_time = 0, m_base = 0, m_lo = 0, cand;
  bit              m_run = 0, m_pulse = 0;
  int              m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_time = 0; m_base = 0; m_lo = 0; m_run = 0; m_pulse = 0; m_cnt = 0;
    end else begin
      cand = {base_wdata, m_lo[31:0]};
      if (!en) begin
        m_run = 0; m_pulse = 0; m_cnt = 0;
      end else if (!m_run) begin
        if (m_time >= m_base) begin m_run = 1; m_pulse = 1; m_cnt = 1; end
        else m_pulse = 0;
      end else if (m_cnt >= ((cycle_len == 0) ? 1 : int'(cycle_len))) begin
        m_pulse = 1; m_cnt = 1;
      end else begin
        m_pulse = 0; m_cnt = m_cnt + 1;
      end
      if (base_hi_we && (!m_run_prev() || cand == 0)) m_base = cand;
      if (base_lo_we) m_lo = {32'd0, base_wdata};
      m_time = m_time + longint'(incr) + 1;
    end
  end

  // Lock decision uses running as it was before this edge
  bit run_before = 0;
  always @(negedge clk) run_before = m_run;
  function automatic bit m_run_prev();
    return run_before;
  endfunction

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R1 time_ns", time_ns, m_time);
      check("R4 running", {63'd0, running}, {63'd0, m_run});
      check("R6 cycle_start", {63'd0, cycle_start}, {63'd0, m_pulse});
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_base(input logic [31:0] lo, input logic [31:0] hi);
    base_lo_we = 1'b1; base_wdata = lo; tick(1);
    base_lo_we = 1'b0; base_hi_we = 1'b1; base_wdata = hi; tick(1);
    base_hi_we = 1'b0; base_wdata = '0;
  endtask

  task automatic count_pulses(input int n, input int exp, input string tag);
    int c = 0;
    bit prev = 1'b0, dbl = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (cycle_start) c++;
      if (cycle_start && prev) dbl = 1'b1;
      prev = cycle_start;
    end
    check(tag, c, exp);
    if (cycle_len >= 2) check("R7 no double pulse", dbl, 0);
  endtask

  initial begin
    longint unsigned tgt, seen;
    int guard;
    tick(3);
    check("R2 reset time", time_ns, 0);
    check("R2 reset running", running, 0);
    check("R2 reset pulse", cycle_start, 0);
    rst = 1'b0;
    tick(5);
    check("R1 time after 5 steps of 10", time_ns, 50);

    // R4: base zero is past, start one clock after enable
    en = 1'b1; tick(1);
    check("R4 immediate running", running, 1);
    check("R4 immediate pulse", cycle_start, 1);
    count_pulses(16, 4, "R6 len 4 pulse count");

    // R8: non-zero base refused while running
    write_base(32'h0000_0010, 32'h0000_0001);
    en = 1'b0; tick(1);
    check("R9 stop running", running, 0);
    check("R9 stop pulse", cycle_start, 0);
    en = 1'b1; tick(1);
    check("R8 refused base keeps old anchor", running, 1);
    write_base(32'd0, 32'd0);
    check("R8 zero base accepted, still running", running, 1);

    // R3: low word alone has no effect
    en = 1'b0; incr = 8'd6; tick(1);
    tgt = time_ns + 64'd2003;
    base_lo_we = 1'b1; base_wdata = tgt[31:0]; tick(1);
    base_lo_we = 1'b0;
    en = 1'b1; tick(1);
    check("R3 low write alone ignored", running, 1);
    en = 1'b0; tick(1);
    base_hi_we = 1'b1; base_wdata = 32'd0; tick(1);
    base_hi_we = 1'b0;
    en = 1'b1; tick(1);
    check("R3 committed future base waits", running, 0);
    guard = 0;
    while (!running && guard < 2000) begin tick(1); guard++; end
    seen = time_ns;
    check("R5 start after base reached", (seen - 7 >= tgt), 1);
    check("R5 start not late", (seen - 14 < tgt), 1);
    check("R5 start pulse", cycle_start, 1);

    // R6: length 0 and 1 pulse every clock, length 3
    en = 1'b0; cycle_len = 16'd0; tick(1);
    en = 1'b1; tick(1);
    count_pulses(8, 8, "R6 len 0 every clock");
    en = 1'b0; cycle_len = 16'd1; tick(1);
    en = 1'b1; tick(1);
    count_pulses(8, 8, "R6 len 1 every clock");
    en = 1'b0; cycle_len = 16'd3; tick(1);
    en = 1'b1; tick(1);
    count_pulses(9, 3, "R6 len 3 pulse count");
    incr = 8'd255; tick(4);
    en = 1'b0; tick(2);
    check("R9 idle after disable", running, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule